// File: doc/BRIEF.md
# Presettable Down Counter/Timer

This block is a processor-side counter/timer peripheral built around a preset down counter of `CNT_W` bits and a holding register of the same width. Software writes a preset, which lands in the holding register and in the counter together, then picks a counting source and starts the counter. When the counter runs out it reloads from the holding register in the same cycle, raises a sticky interrupt request, and can flip a single-bit output pin. The live count is always on `count_out` for reads.

There are three counting sources. Timebase mode decrements once for every `PRE_DIV` pulses of the machine timing strobe `tick_in`. Event mode decrements on each high-to-low transition of one of the external flag inputs. Pulse-width mode decrements on prescaled timebase ticks only while the selected flag is held low, and ends the measurement when that flag returns high. The flags are asynchronous and each passes through its own two-flop synchronizer.

The control sequence is a four-state machine. `ST_IDLE` is entered from reset, on a stop command, and when a pulse measurement ends. A start command accepted in `ST_IDLE`, or in any running state, moves to `ST_TIME` (mode code 00), `ST_EVENT` (mode code 01) or `ST_PULSE` (mode code 10). `ST_PULSE` returns to `ST_IDLE` on its own when the gate flag rises. A stop command moves any state to `ST_IDLE`. Every other case stays in the current state.

Top module: `dcnt_timer`

## Requirements
- R1: After reset the count is 0, the holding register is 0, `irq` is 0, `q_out` is 0 and the machine is idle, so `tick_in` pulses leave the count unchanged.
- R2: A cycle with `load_en` high writes `load_val` into both the holding register and the counter, and the new value appears on `count_out` in the next cycle. A load takes priority over any decrement in the same cycle.
- R3: In timebase mode (`mode_in` = 2'b00) the counter decrements once for every `PRE_DIV` `tick_in` pulses. Accepting a start clears the prescaler, so the first decrement follows the `PRE_DIV`-th pulse after the start.
- R4: In event mode (`mode_in` = 2'b01) the counter decrements once for each high-to-low transition of the flag chosen by `flag_sel` (0 selects `flag_in[0]`, 1 selects `flag_in[1]`), within three cycles of the transition. The flag that is not selected has no effect.
- R5: In pulse-width mode (`mode_in` = 2'b10) the counter decrements on prescaled ticks only while the selected flag is low. When that flag goes from low to high, counting stops, the count is held, `irq` is set and the machine returns to idle.
- R6: A decrement taken while the count is 1 or 0 loads the counter from the holding register instead of decrementing it, and sets `irq`.
- R7: `irq` stays set until a cycle with `irq_ack` high clears it. A new set request in the same cycle as `irq_ack` wins.
- R8: When `q_route_en` is 1, `q_out` toggles on every underflow. When `q_route_en` is 0, `q_out` keeps its value.
- R9: A stop command freezes the count without clearing it, and it wins over a start in the same cycle. A later start resumes counting from the frozen value.
- R10: A start with `mode_in` = 2'b11 is ignored. The machine stays in its current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | Machine timing strobe, one cycle per pulse |
| flag_in | input | NFLAG | Asynchronous external flag inputs |
| flag_sel | input | $clog2(NFLAG) | Flag chosen for event and pulse-width modes, latched on start |
| mode_in | input | 2 | Counting source code, latched on start |
| start | input | 1 | Start command |
| stop | input | 1 | Stop command, freezes the count |
| load_en | input | 1 | Write `load_val` to the holding register and the counter |
| load_val | input | CNT_W | Preset value |
| q_route_en | input | 1 | Lets an underflow toggle `q_out` |
| irq_ack | input | 1 | Clears the interrupt request |
| count_out | output | CNT_W | Live count |
| irq | output | 1 | Sticky interrupt request |
| q_out | output | 1 | Output toggled by underflow when routing is enabled |

## Verification
The bench keeps `CNT_W` at 8 and `NFLAG` at 2, so both flag selections and the exclusion of the unselected flag get exercised. It sets `PRE_DIV` to 4 instead of 32. That way a few dozen `tick_in` pulses are enough to walk through prescaler wrap, several decrements, an underflow reload from a small preset, and a gated pulse-width measurement, all within a short run.

// File: rtl/dct_pkg.sv
package dct_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TIME  = 2'd1,
        ST_EVENT = 2'd2,
        ST_PULSE = 2'd3
    } dct_state_e;

    localparam logic [1:0] MODE_TIME  = 2'b00;
    localparam logic [1:0] MODE_EVENT = 2'b01;
    localparam logic [1:0] MODE_PULSE = 2'b10;
    localparam logic [1:0] MODE_RSVD  = 2'b11;
endpackage

// File: rtl/dct_sync.sv
module dct_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic lvl,
    output logic fall,
    output logic rise
);
    logic s1, s2, s3;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= d;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign lvl  = s2;
    assign fall = s3 & ~s2;
    assign rise = ~s3 & s2;
endmodule

// File: rtl/dct_prescale.sv
module dct_prescale #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick_in,
    output logic tick_out
);
    localparam int PC_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PC_W-1:0] LAST = PC_W'(DIV - 1);

    logic [PC_W-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pc_q <= '0;
        end else if (tick_in) begin
            pc_q <= (pc_q == LAST) ? '0 : pc_q + 1'b1;
        end
    end

    assign tick_out = tick_in && !clr && (pc_q == LAST);
endmodule

// File: rtl/dcnt_timer.sv
module dcnt_timer #(
    parameter int CNT_W   = 8,
    parameter int PRE_DIV = 32,
    parameter int NFLAG   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_in,
    input  logic [NFLAG-1:0]           flag_in,
    input  logic [$clog2(NFLAG)-1:0]   flag_sel,
    input  logic [1:0]                 mode_in,
    input  logic                       start,
    input  logic                       stop,
    input  logic                       load_en,
    input  logic [CNT_W-1:0]           load_val,
    input  logic                       q_route_en,
    input  logic                       irq_ack,
    output logic [CNT_W-1:0]           count_out,
    output logic                       irq,
    output logic                       q_out
);
    import dct_pkg::*;

    localparam int SEL_W = $clog2(NFLAG);

    dct_state_e        state_q, state_d;
    logic [SEL_W-1:0]  sel_q;
    logic [CNT_W-1:0]  count_q, hold_q;
    logic [NFLAG-1:0]  lvl, fall, rise;
    logic              tb_tick, start_ok, dec_en, underflow, pw_done;
    logic              lvl_sel, fall_sel, rise_sel;

    for (genvar g = 0; g < NFLAG; g++) begin : g_sync
        dct_sync u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (flag_in[g]),
            .lvl  (lvl[g]),
            .fall (fall[g]),
            .rise (rise[g])
        );
    end

    assign start_ok = start && !stop && (mode_in != MODE_RSVD);

    dct_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start_ok),
        .tick_in (tick_in),
        .tick_out(tb_tick)
    );

    assign lvl_sel  = lvl[sel_q];
    assign fall_sel = fall[sel_q];
    assign rise_sel = rise[sel_q];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start_ok) sel_q <= flag_sel;
        end
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (stop) begin
            state_d = ST_IDLE;
        end else if (start_ok) begin
            unique case (mode_in)
                MODE_TIME:  state_d = ST_TIME;
                MODE_EVENT: state_d = ST_EVENT;
                default:    state_d = ST_PULSE;
            endcase
        end else if (state_q == ST_PULSE && rise_sel) begin
            state_d = ST_IDLE;
        end
    end

    // decrement source per state
    always_comb begin
        unique case (state_q)
            ST_IDLE:  dec_en = 1'b0;
            ST_TIME:  dec_en = tb_tick;
            ST_EVENT: dec_en = fall_sel;
            ST_PULSE: dec_en = tb_tick && !lvl_sel;
            default:  dec_en = 1'b0;
        endcase
    end

    assign underflow = dec_en && (count_q <= CNT_W'(1));
    assign pw_done   = (state_q == ST_PULSE) && rise_sel;

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            hold_q  <= '0;
            irq     <= 1'b0;
            q_out   <= 1'b0;
        end else begin
            if (load_en) begin
                hold_q  <= load_val;
                count_q <= load_val;
            end else if (underflow) begin
                count_q <= hold_q;
            end else if (dec_en) begin
                count_q <= count_q - 1'b1;
            end

            if (underflow || pw_done) irq <= 1'b1;
            else if (irq_ack)         irq <= 1'b0;

            if (underflow && q_route_en) q_out <= ~q_out;
        end
    end

    assign count_out = count_q;
endmodule

// File: rtl/dcnt_timer_chk.sv
module dcnt_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               load_en,
    input logic [CNT_W-1:0]   load_val,
    input logic [1:0]         mode_in,
    input logic               irq,
    input logic               irq_ack,
    input logic               q_out,
    input logic               q_route_en,
    input logic [CNT_W-1:0]   count_out,
    input logic [CNT_W-1:0]   hold_q,
    input dct_pkg::dct_state_e st,
    input logic               dec_en
);
    import dct_pkg::*;

    // R2
    load_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> count_out == $past(load_val));

    // R6
    underflow_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && dec_en && count_out <= CNT_W'(1)) |=> (count_out == hold_q && irq));

    // R7
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);

    // R8
    q_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q_route_en |=> $stable(q_out));

    // R9
    idle_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !load_en) |=> $stable(count_out));

    // R10
    rsvd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && mode_in == MODE_RSVD) |=> st == ST_IDLE);
endmodule

bind dcnt_timer dcnt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_val  (load_val),
    .mode_in   (mode_in),
    .irq       (irq),
    .irq_ack   (irq_ack),
    .q_out     (q_out),
    .q_route_en(q_route_en),
    .count_out (count_out),
    .hold_q    (hold_q),
    .st        (state_q),
    .dec_en    (dec_en)
);

// File: tb/dcnt_timer_tb.sv
module dcnt_timer_tb;
    localparam int CNT_W = 8;
    localparam int PRE_DIV = 4;
    localparam int NFLAG = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_in = 1'b0;
    logic [NFLAG-1:0] flag_in = '1;
    logic [0:0]       flag_sel = 1'b0;
    logic [1:0]       mode_in = 2'b00;
    logic             start = 1'b0, stop = 1'b0, load_en = 1'b0;
    logic [CNT_W-1:0] load_val = '0;
    logic             q_route_en = 1'b0, irq_ack = 1'b0;
    logic [CNT_W-1:0] count_out;
    logic             irq, q_out;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dcnt_timer #(.CNT_W(CNT_W), .PRE_DIV(PRE_DIV), .NFLAG(NFLAG)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .flag_in(flag_in),
        .flag_sel(flag_sel), .mode_in(mode_in), .start(start), .stop(stop),
        .load_en(load_en), .load_val(load_val), .q_route_en(q_route_en),
        .irq_ack(irq_ack), .count_out(count_out), .irq(irq), .q_out(q_out)
    );

    task automatic cyc(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_in = 1'b1; cyc();
            tick_in = 1'b0; cyc();
        end
    endtask

    task automatic do_load(input int v);
        load_val = CNT_W'(v); load_en = 1'b1; cyc();
        load_en = 1'b0;
    endtask

    task automatic do_start(input logic [1:0] m, input logic s);
        mode_in = m; flag_sel = s; start = 1'b1; cyc();
        start = 1'b0;
    endtask

    task automatic do_stop();
        stop = 1'b1; cyc();
        stop = 1'b0;
    endtask

    task automatic do_ack();
        irq_ack = 1'b1; cyc();
        irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 count", count_out, 0);
        check("R1 irq", irq, 0);
        check("R1 q", q_out, 0);
        ticks(8);
        check("R1 idle ticks", count_out, 0);
    endtask

    task automatic t_load();
        do_load(42);
        check("R2 load", count_out, 42);
    endtask

    task automatic t_timebase();
        do_load(5);
        do_start(2'b00, 1'b0);
        ticks(3);
        check("R3 before wrap", count_out, 5);
        ticks(1);
        check("R3 first dec", count_out, 4);
        ticks(8);
        check("R3 two more", count_out, 2);
        do_load(9);
        check("R2 load while running", count_out, 9);
        do_stop();
    endtask

    task automatic t_underflow_q();
        do_ack();
        q_route_en = 1'b1;
        do_load(2);
        do_start(2'b00, 1'b0);
        ticks(4);
        check("R6 at one", count_out, 1);
        check("R6 irq low", irq, 0);
        ticks(4);
        check("R6 reload", count_out, 2);
        check("R6 irq", irq, 1);
        check("R8 toggle", q_out, 1);
        q_route_en = 1'b0;
        ticks(8);
        check("R8 no toggle", q_out, 1);
        check("R7 sticky", irq, 1);
        do_stop();
        do_ack();
        check("R7 ack clears", irq, 0);
    endtask

    task automatic t_event();
        do_load(10);
        do_start(2'b01, 1'b1);
        flag_in[0] = 1'b0; cyc(4);
        flag_in[0] = 1'b1; cyc(4);
        check("R4 unselected", count_out, 10);
        flag_in[1] = 1'b0; cyc(4);
        check("R4 first edge", count_out, 9);
        flag_in[1] = 1'b1; cyc(4);
        check("R4 rising no dec", count_out, 9);
        flag_in[1] = 1'b0; cyc(4);
        flag_in[1] = 1'b1; cyc(4);
        check("R4 second edge", count_out, 8);
        do_stop();
    endtask

    task automatic t_pulse();
        do_ack();
        do_load(20);
        do_start(2'b10, 1'b0);
        ticks(4);
        check("R5 gate inactive", count_out, 20);
        flag_in[0] = 1'b0; cyc(3);
        ticks(8);
        check("R5 gated count", count_out, 18);
        check("R5 no irq yet", irq, 0);
        flag_in[0] = 1'b1; cyc(4);
        check("R5 end irq", irq, 1);
        check("R5 held", count_out, 18);
        flag_in[0] = 1'b0; cyc(3);
        ticks(8);
        check("R5 stopped", count_out, 18);
        flag_in[0] = 1'b1; cyc(4);
        do_ack();
    endtask

    task automatic t_stop();
        do_load(7);
        do_start(2'b00, 1'b0);
        ticks(4);
        check("R9 running", count_out, 6);
        do_stop();
        ticks(8);
        check("R9 frozen", count_out, 6);
        mode_in = 2'b00; start = 1'b1; stop = 1'b1; cyc();
        start = 1'b0; stop = 1'b0;
        ticks(8);
        check("R9 stop wins", count_out, 6);
        do_start(2'b00, 1'b0);
        ticks(4);
        check("R9 resume", count_out, 5);
        do_stop();
    endtask

    task automatic t_rsvd();
        do_load(3);
        do_start(2'b11, 1'b0);
        ticks(8);
        check("R10 ignored", count_out, 3);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_load();
        t_timebase();
        t_underflow_q();
        t_event();
        t_pulse();
        t_stop();
        t_rsvd();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule